// File: doc/BRIEF.md
# LFSR Paged Program Sequencer

This block produces instruction fetch addresses for a small microcontroller core. The in-page program counter is a 6-bit linear-feedback shift register, not a binary counter, so moving to the next instruction costs one shift and one XNOR gate. Program memory is split into pages of 64 slots. A page register, separate from the counter, selects the page. Branch and call instructions carry only a 6-bit in-page target. To reach another page, a load-page instruction must first place the wanted page in a page buffer; the next taken branch or call then copies that buffer into the page register.

The core's decoder drives one-cycle strobes into the sequencer: advance, branch, call, return and load-page. It also supplies the target field, the page operand and a condition bit. Conditional transfers work by skipping: when the condition bit is low, a branch or call is not taken and the counter just shifts. There is one return level. A call saves the successor of its own address and uses the page buffer to hold the return page. A return restores both. A call made from inside a subroutine replaces the saved return without any error being flagged.

Top module: `lfsr_page_seq`

## Requirements
- R1: While rstN is low, and on the first cycle after it is released, fetchAddr is 0 and fetchPage is 0. The page buffer and the saved return address also reset to 0.
- R2: When advance is low, fetchAddr, fetchPage, the page buffer and the saved return stay unchanged on that edge, whatever the other strobes are.
- R3: On an advance with no branch, call or return strobe, the new fetchAddr is {a[4:0], ~(a[5] ^ a[4])}, where a is the old fetchAddr, and fetchPage does not change.
- R4: Starting from 0, plain advances visit 63 distinct addresses and return to 0 after exactly 63 steps. The value 6'h3F never appears on fetchAddr.
- R5: An advance with isLoadPage alone steps the counter as in R3 and leaves fetchPage unchanged. It loads pageOperand into the page buffer, and the next taken branch or call shows that value on fetchPage.
- R6: A taken branch (advance, isBranch, condOk high) loads targetAddr into fetchAddr and the page buffer into fetchPage. The buffer itself keeps its value.
- R7: A branch or call with condOk low steps the counter as in R3. It leaves fetchPage, the page buffer and the saved return unchanged.
- R8: A taken call loads targetAddr into fetchAddr and the page buffer into fetchPage. It saves the R3 successor of the call address as the return address and moves the old fetchPage into the page buffer.
- R9: A return is taken whatever condOk is. It loads the saved return address into fetchAddr and the page buffer into fetchPage.
- R10: A taken call issued inside a subroutine overwrites the single saved return. The following return goes to the successor of the second call, on the page that was current at the second call.
- R11: When several strobes are asserted together, the first in this list wins and the others are ignored: return, call, branch, load-page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| advance | input | 1 | Instruction completes this cycle; enables every update |
| isBranch | input | 1 | Branch strobe |
| isCall | input | 1 | Call strobe |
| isReturn | input | 1 | Return strobe |
| isLoadPage | input | 1 | Load page buffer from pageOperand |
| condOk | input | 1 | Status condition; low makes branch and call skip |
| targetAddr | input | PC_W (6) | In-page target of a branch or call |
| pageOperand | input | PAGE_W (4) | Page value for load-page |
| fetchAddr | output | PC_W (6) | Registered in-page fetch address |
| fetchPage | output | PAGE_W (4) | Registered fetch page |

## Verification
The bench first walks the whole 63-state counter cycle with plain advances, which proves the step rule, the cycle length and that the lockup value is never reached. Branches are then run against every page value with targets that include 0 and the highest legal slot; this shows that the buffer, not the operand, drives the page. Calls with the condition low, followed by returns, show that a skipped call leaves the saved return alone. A nested call shows the overwrite. Combined strobes and advance-low cycles separate the priority order from the hold behaviour.

// File: rtl/lfsr_page_seq_pkg.sv
package lfsr_page_seq_pkg;

  typedef enum logic [1:0] {
    PC_HOLD    = 2'd0,
    PC_STEP    = 2'd1,
    PC_JUMP    = 2'd2,
    PC_RESTORE = 2'd3
  } pcSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   pageFromBuf;
    logic   bufFromOperand;
    logic   bufFromPage;
    logic   saveRet;
  } seqCtl_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import lfsr_page_seq_pkg::*;
(
  input  logic    advance,
  input  logic    isBranch,
  input  logic    isCall,
  input  logic    isReturn,
  input  logic    isLoadPage,
  input  logic    condOk,
  output seqCtl_t ctl
);

  always_comb begin
    ctl = '{pcSel: PC_HOLD, pageFromBuf: 1'b0, bufFromOperand: 1'b0,
            bufFromPage: 1'b0, saveRet: 1'b0};
    if (advance) begin
      if (isReturn) begin
        ctl.pcSel       = PC_RESTORE;
        ctl.pageFromBuf = 1'b1;
      end else if (isCall) begin
        if (condOk) begin
          ctl.pcSel       = PC_JUMP;
          ctl.pageFromBuf = 1'b1;
          ctl.bufFromPage = 1'b1;
          ctl.saveRet     = 1'b1;
        end else begin
          ctl.pcSel = PC_STEP;
        end
      end else if (isBranch) begin
        if (condOk) begin
          ctl.pcSel       = PC_JUMP;
          ctl.pageFromBuf = 1'b1;
        end else begin
          ctl.pcSel = PC_STEP;
        end
      end else if (isLoadPage) begin
        ctl.pcSel          = PC_STEP;
        ctl.bufFromOperand = 1'b1;
      end else begin
        ctl.pcSel = PC_STEP;
      end
    end
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import lfsr_page_seq_pkg::*;
#(
  parameter int PC_W   = 6,
  parameter int PAGE_W = 4,
  parameter int TAP_HI = PC_W - 1,
  parameter int TAP_LO = PC_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [PC_W-1:0]   targetAddr,
  input  logic [PAGE_W-1:0] pageOperand,
  output logic [PC_W-1:0]   pcQ,
  output logic [PAGE_W-1:0] pageQ
);

  logic [PC_W-1:0]   retQ;
  logic [PAGE_W-1:0] bufQ;
  logic [PC_W-1:0]   pcNext;

  // XNOR feedback: the all-ones word is the only state outside the cycle
  assign pcNext = {pcQ[PC_W-2:0], ~(pcQ[TAP_HI] ^ pcQ[TAP_LO])};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= '0;
      pageQ <= '0;
      bufQ  <= '0;
      retQ  <= '0;
    end else begin
      unique case (ctl.pcSel)
        PC_STEP:    pcQ <= pcNext;
        PC_JUMP:    pcQ <= targetAddr;
        PC_RESTORE: pcQ <= retQ;
        default:    pcQ <= pcQ;
      endcase
      if (ctl.saveRet)     retQ  <= pcNext;
      if (ctl.pageFromBuf) pageQ <= bufQ;
      if (ctl.bufFromOperand)   bufQ <= pageOperand;
      else if (ctl.bufFromPage) bufQ <= pageQ;
    end
  end

endmodule

// File: rtl/lfsr_page_seq.sv
module lfsr_page_seq
  import lfsr_page_seq_pkg::*;
#(
  parameter int PC_W   = 6,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              isBranch,
  input  logic              isCall,
  input  logic              isReturn,
  input  logic              isLoadPage,
  input  logic              condOk,
  input  logic [PC_W-1:0]   targetAddr,
  input  logic [PAGE_W-1:0] pageOperand,
  output logic [PC_W-1:0]   fetchAddr,
  output logic [PAGE_W-1:0] fetchPage
);

  seqCtl_t ctl;

  seq_ctrl u_ctrl (
    .advance   (advance),
    .isBranch  (isBranch),
    .isCall    (isCall),
    .isReturn  (isReturn),
    .isLoadPage(isLoadPage),
    .condOk    (condOk),
    .ctl       (ctl)
  );

  seq_datapath #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .targetAddr (targetAddr),
    .pageOperand(pageOperand),
    .pcQ        (fetchAddr),
    .pageQ      (fetchPage)
  );

endmodule

// File: rtl/lfsr_page_seq_chk.sv
module lfsr_page_seq_chk #(
  parameter int PC_W   = 6,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              advance,
  input logic              isBranch,
  input logic              isCall,
  input logic              isReturn,
  input logic              condOk,
  input logic [PC_W-1:0]   targetAddr,
  input logic [PC_W-1:0]   fetchAddr,
  input logic [PAGE_W-1:0] fetchPage
);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(fetchAddr) && $stable(fetchPage));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    advance && !isBranch && !isCall && !isReturn |=>
      fetchAddr == {$past(fetchAddr[PC_W-2:0]),
                    ~($past(fetchAddr[PC_W-1]) ^ $past(fetchAddr[PC_W-2]))}
      && $stable(fetchPage));

  // R4
  no_lockup_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchAddr != {PC_W{1'b1}});

  // R6
  branch_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    advance && isBranch && condOk && !isCall && !isReturn |=>
      fetchAddr == $past(targetAddr));

  // R7
  skip_keeps_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    advance && (isBranch || isCall) && !condOk && !isReturn |=>
      $stable(fetchPage));

endmodule

bind lfsr_page_seq lfsr_page_seq_chk #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .advance   (advance),
  .isBranch  (isBranch),
  .isCall    (isCall),
  .isReturn  (isReturn),
  .condOk    (condOk),
  .targetAddr(targetAddr),
  .fetchAddr (fetchAddr),
  .fetchPage (fetchPage)
);

// File: tb/lfsr_page_seq_bench.sv
`timescale 1ns/1ps
module lfsr_page_seq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       advance = 1'b0, isBranch = 1'b0, isCall = 1'b0;
  logic       isReturn = 1'b0, isLoadPage = 1'b0, condOk = 1'b0;
  logic [5:0] targetAddr = '0;
  logic [3:0] pageOperand = '0;
  logic [5:0] fetchAddr;
  logic [3:0] fetchPage;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural model state
  logic [5:0] mPc = '0, mRet = '0;
  logic [3:0] mPage = '0, mBuf = '0;

  always #2 clk = ~clk;  // 250 MHz

  lfsr_page_seq u_lfsr_page_seq (
    .clk(clk), .rstN(rstN), .advance(advance), .isBranch(isBranch),
    .isCall(isCall), .isReturn(isReturn), .isLoadPage(isLoadPage),
    .condOk(condOk), .targetAddr(targetAddr), .pageOperand(pageOperand),
    .fetchAddr(fetchAddr), .fetchPage(fetchPage)
  );

  function automatic logic [5:0] nextAddr(input logic [5:0] a);
    return {a[4:0], ~(a[5] ^ a[4])};
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (fetchAddr !== mPc || fetchPage !== mPage) begin
      miscompares++;
      $display("FAIL %s: addr=%h page=%h expected addr=%h page=%h",
               tag, fetchAddr, fetchPage, mPc, mPage);
    end
  endtask

  // drive one cycle (inputs set at negedge), update model, check at next negedge
  task automatic cyc(input logic adv, input logic br, input logic cl,
                     input logic rt, input logic lp, input logic cd,
                     input logic [5:0] tgt, input logic [3:0] pop,
                     input string tag);
    advance = adv; isBranch = br; isCall = cl; isReturn = rt;
    isLoadPage = lp; condOk = cd; targetAddr = tgt; pageOperand = pop;
    if (adv) begin
      if (rt) begin
        mPc = mRet; mPage = mBuf;
      end else if (cl) begin
        if (cd) begin
          mRet = nextAddr(mPc); mPc = tgt;
          begin logic [3:0] t; t = mPage; mPage = mBuf; mBuf = t; end
        end else mPc = nextAddr(mPc);
      end else if (br) begin
        if (cd) begin mPc = tgt; mPage = mBuf; end
        else mPc = nextAddr(mPc);
      end else if (lp) begin
        mBuf = pop; mPc = nextAddr(mPc);
      end else mPc = nextAddr(mPc);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic step(input string tag);
    cyc(1, 0, 0, 0, 0, 0, 6'h00, 4'h0, tag);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");                     // during reset
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1");                     // idle cycle after release

    // R4 / R3: full cycle walk
    begin
      bit seen[64];
      foreach (seen[i]) seen[i] = 0;
      seen[0] = 1;
      for (int i = 1; i <= 63; i++) begin
        step("R3");
        vectors++;
        if (fetchAddr == 6'h3F || (i < 63 && seen[fetchAddr])) begin
          miscompares++;
          $display("FAIL R4: addr=%h at step %0d expected fresh non-3F value", fetchAddr, i);
        end
        seen[fetchAddr] = 1;
      end
      vectors++;
      if (fetchAddr !== 6'h00) begin
        miscompares++;
        $display("FAIL R4: addr=%h after 63 steps expected 00", fetchAddr);
      end
    end

    // R2: advance low with every strobe pattern
    for (int s = 0; s < 32; s++)
      cyc(0, s[0], s[1], s[2], s[3], s[4], 6'h15, 4'hA, "R2");
    step("R2");  // buffer must still be 0: show via branch
    cyc(1, 1, 0, 0, 0, 1, 6'h07, 4'h0, "R2");

    // R5 / R6: every page, several targets
    for (int p = 0; p < 16; p++) begin
      for (int t = 0; t < 4; t++) begin
        logic [5:0] tg;
        tg = (t == 0) ? 6'h00 : (t == 1) ? 6'h01 : (t == 2) ? 6'h2A : 6'h3E;
        cyc(1, 0, 0, 0, 1, 0, 6'h00, p[3:0], "R5");
        step("R5");
        cyc(1, 1, 0, 0, 0, 1, tg, 4'(15 - p), "R6");
        cyc(1, 1, 0, 0, 0, 1, nextAddr(tg), 4'h0, "R6");  // buffer kept
      end
    end

    // R8 / R9: call and return across pages
    for (int k = 0; k < 8; k++) begin
      cyc(1, 0, 0, 0, 1, 0, 6'h00, 4'(k + 3), "R8");
      step("R8");
      cyc(1, 0, 1, 0, 0, 1, 6'(k * 7), 4'h0, "R8");
      step("R8");
      cyc(1, 0, 0, 1, 0, k[0], 6'h3E, 4'h0, "R9");
      step("R9");
    end

    // R7: skipped call keeps the saved return; skipped branch keeps page
    cyc(1, 0, 0, 0, 1, 0, 6'h00, 4'h9, "R7");
    cyc(1, 0, 1, 0, 0, 1, 6'h11, 4'h0, "R7");
    step("R7");
    cyc(1, 0, 1, 0, 0, 0, 6'h22, 4'h0, "R7");
    cyc(1, 1, 0, 0, 0, 0, 6'h33, 4'h0, "R7");
    cyc(1, 0, 0, 1, 0, 1, 6'h00, 4'h0, "R7");

    // R10: nested call overwrites the single return level
    cyc(1, 0, 0, 0, 1, 0, 6'h00, 4'h5, "R10");
    cyc(1, 0, 1, 0, 0, 1, 6'h0C, 4'h0, "R10");
    step("R10");
    cyc(1, 0, 0, 0, 1, 0, 6'h00, 4'hC, "R10");
    cyc(1, 0, 1, 0, 0, 1, 6'h30, 4'h0, "R10");
    step("R10");
    cyc(1, 0, 0, 1, 0, 0, 6'h00, 4'h0, "R10");
    step("R10");

    // R11: priority among simultaneous strobes
    cyc(1, 0, 0, 0, 1, 0, 6'h00, 4'h2, "R11");
    cyc(1, 1, 1, 0, 1, 1, 6'h19, 4'h8, "R11");   // call wins
    step("R11");
    cyc(1, 1, 1, 1, 1, 1, 6'h05, 4'h7, "R11");   // return wins
    cyc(1, 1, 0, 0, 1, 1, 6'h2B, 4'hF, "R11");   // branch wins, buffer kept
    cyc(1, 1, 0, 0, 0, 1, 6'h04, 4'h0, "R11");   // shows buffer unchanged

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule